// File: doc/BRIEF.md
# Image Sensor Readout Timing Generator

This block sequences the readout of a windowed region of a 668-column by 496-row pixel array. From a single master clock it produces a frame qualifier, a line qualifier, a per-pixel valid strobe and the array row and column of the pixel being delivered. Downstream logic uses these to capture pixel data and to know where in the array each sample came from.

Eight configuration inputs shape each frame: the first row and first column, the window height and width, the horizontal blanking length in clocks, the vertical blanking length in row times, a pixel-clock control value that sets the blanking before and after the active rows, and a column-skip enable that halves the number of columns read. The block samples all of them once per frame, in the single low cycle of the frame qualifier just before it rises. A change made while a frame is running therefore takes effect on the next frame. The optically black margin (the first 18 columns and first 6 rows) can be addressed like any other region.

Top module: `sensor_readout_timer`

## Requirements
- R1: While reset is asserted, frame_valid_o, line_valid_o and pixel_valid_o are low.
- R2: Each frame opens with exactly 6 × (P + 2) clocks in which frame_valid_o is high and line_valid_o is low, where P is cfg_pclk_div_i. line_valid_o is never high while frame_valid_o is low.
- R3: After the last pixel of the last row, frame_valid_o stays high with line_valid_o low for exactly 6 × (P + 2) clocks and then falls.
- R4: Each row asserts line_valid_o for N consecutive clocks, where N is the number of columns read. pixel_valid_o equals line_valid_o in every cycle.
- R5: Between two rows of one frame, line_valid_o is low and frame_valid_o high for max(H, 1) clocks, where H is cfg_hblank_i.
- R6: Between frames, frame_valid_o is low for 1 + V × (N + max(H, 1)) clocks, where V is cfg_vblank_i.
- R7: Rows are read in ascending order starting at the first row. Within a row, columns ascend by one from the first column.
- R8: With cfg_col_skip_i = 1, columns ascend by two and N = ceil(W / 2) for a clamped width W.
- R9: A first row above 495 is taken as 495, and a first column above 667 as 667. The height is limited to 496 minus the first row and the width to 668 minus the first column. A height or width of 0 is taken as 1. row_o never exceeds 495 and col_o never exceeds 667.
- R10: Configuration inputs are sampled only in the frame_valid_o-low cycle just before frame_valid_o rises. Changes made during a frame do not alter that frame.
- R11: The optically black margin is addressable: a window at row 0, column 0 delivers pixel (0, 0) first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_row_first_i | input | 9 | First array row of the window |
| cfg_col_first_i | input | 10 | First array column of the window |
| cfg_rows_i | input | 9 | Window height in rows |
| cfg_cols_i | input | 10 | Window width in columns |
| cfg_hblank_i | input | 10 | Horizontal blanking in clocks |
| cfg_vblank_i | input | 8 | Vertical blanking in row times |
| cfg_pclk_div_i | input | 8 | Pixel-clock control value P for frame edge blanking |
| cfg_col_skip_i | input | 1 | Read every other column |
| frame_valid_o | output | 1 | Frame qualifier |
| line_valid_o | output | 1 | Line qualifier |
| pixel_valid_o | output | 1 | One pulse per delivered pixel |
| row_o | output | 9 | Array row of the current pixel |
| col_o | output | 10 | Array column of the current pixel |

## Verification
Two events can fall in the same cycle: the end of the last active row and the end of the frame, and a configuration write and the first pixel of a running frame. For the first, the bench counts the blanking after each line. It accepts the horizontal length only when another line follows and the edge blanking only when the frame qualifier then falls. For the second, the bench rewrites every configuration input exactly on the first pixel of a frame. It then checks that frame's full coordinate sequence against the old settings and the next frame against the new ones.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  localparam int ARRAY_COLS = 668;
  localparam int ARRAY_ROWS = 496;
  localparam int ROW_W      = $clog2(ARRAY_ROWS);
  localparam int COL_W      = $clog2(ARRAY_COLS);
  localparam int HB_W       = 10;
  localparam int VB_W       = 8;
  localparam int PCC_W      = 8;
  localparam int CNT_W      = 16;
  localparam int EDGE_MULT  = 6;
  localparam int EDGE_BIAS  = 2;

  typedef enum logic [2:0] {
    ST_LOAD = 3'd0,
    ST_SOF  = 3'd1,
    ST_LINE = 3'd2,
    ST_HBL  = 3'd3,
    ST_EOF  = 3'd4,
    ST_VBL  = 3'd5
  } rdt_state_e;

  typedef struct packed {
    logic [ROW_W-1:0] row_first;
    logic [ROW_W-1:0] row_count;
    logic [COL_W-1:0] col_first;
    logic [COL_W-1:0] pix_count;
    logic             col_skip;
    logic [CNT_W-1:0] hbl_len;
    logic [VB_W-1:0]  vbl_rows;
    logic [CNT_W-1:0] edge_len;
    logic [CNT_W-1:0] row_len;
  } rdt_frame_cfg_t;
endpackage

// File: rtl/rdt_cfg_shadow.sv
module rdt_cfg_shadow
  import rdt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [ROW_W-1:0]     row_first_i,
  input  logic [COL_W-1:0]     col_first_i,
  input  logic [ROW_W-1:0]     rows_i,
  input  logic [COL_W-1:0]     cols_i,
  input  logic [HB_W-1:0]      hblank_i,
  input  logic [VB_W-1:0]      vblank_i,
  input  logic [PCC_W-1:0]     pclk_div_i,
  input  logic                 col_skip_i,
  output logic [CNT_W-1:0]     edge_len_d,
  output rdt_frame_cfg_t       cfg_q
);
  localparam logic [ROW_W-1:0] ROW_MAX  = ROW_W'(ARRAY_ROWS - 1);
  localparam logic [COL_W-1:0] COL_MAX  = COL_W'(ARRAY_COLS - 1);
  localparam logic [ROW_W-1:0] ROW_SPAN = ROW_W'(ARRAY_ROWS);
  localparam logic [COL_W-1:0] COL_SPAN = COL_W'(ARRAY_COLS);

  logic [ROW_W-1:0] row_first_c, rows_room, rows_c;
  logic [COL_W-1:0] col_first_c, cols_room, cols_c, pix_c;
  logic [CNT_W-1:0] hbl_c, edge_c;
  rdt_frame_cfg_t   cfg_d;

  // clamp the window into the array
  always_comb begin
    row_first_c = (row_first_i > ROW_MAX) ? ROW_MAX : row_first_i;
    rows_room   = ROW_SPAN - row_first_c;
    if (rows_i == '0)           rows_c = ROW_W'(1);
    else if (rows_i > rows_room) rows_c = rows_room;
    else                        rows_c = rows_i;

    col_first_c = (col_first_i > COL_MAX) ? COL_MAX : col_first_i;
    cols_room   = COL_SPAN - col_first_c;
    if (cols_i == '0)           cols_c = COL_W'(1);
    else if (cols_i > cols_room) cols_c = cols_room;
    else                        cols_c = cols_i;

    pix_c  = col_skip_i ? COL_W'((cols_c + COL_W'(1)) >> 1) : cols_c;
    hbl_c  = (hblank_i == '0) ? CNT_W'(1) : CNT_W'(hblank_i);
    edge_c = CNT_W'(EDGE_MULT) * (CNT_W'(pclk_div_i) + CNT_W'(EDGE_BIAS));
  end

  always_comb begin
    cfg_d.row_first = row_first_c;
    cfg_d.row_count = rows_c;
    cfg_d.col_first = col_first_c;
    cfg_d.pix_count = pix_c;
    cfg_d.col_skip  = col_skip_i;
    cfg_d.hbl_len   = hbl_c;
    cfg_d.vbl_rows  = vblank_i;
    cfg_d.edge_len  = edge_c;
    cfg_d.row_len   = CNT_W'(pix_c) + hbl_c;
  end

  assign edge_len_d = edge_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (load_en) cfg_q <= cfg_d;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/rdt_step_counter.sv
module rdt_step_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt_q != '0)); // R5
endmodule

// File: rtl/rdt_coord_gen.sv
module rdt_coord_gen
  import rdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             row_next,
  input  logic             line_start,
  input  logic             col_next,
  input  logic [ROW_W-1:0] row_first,
  input  logic [COL_W-1:0] col_first,
  input  logic             col_skip,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [COL_W-1:0] col_step;

  always_comb begin
    col_step = col_skip ? COL_W'(2) : COL_W'(1);
    row_d = row_q;
    if (frame_start)   row_d = row_first;
    else if (row_next) row_d = row_q + ROW_W'(1);
    col_d = col_q;
    if (line_start)    col_d = col_first;
    else if (col_next) col_d = col_q + col_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (frame_start || row_next) row_q <= row_d;
      if (line_start || col_next)  col_q <= col_d;
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;

  AST_ROW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= ROW_W'(ARRAY_ROWS - 1)); // R9
  AST_COL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_W'(ARRAY_COLS - 1)); // R9
endmodule

// File: rtl/sensor_readout_timer.sv
module sensor_readout_timer
  import rdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] cfg_row_first_i,
  input  logic [COL_W-1:0] cfg_col_first_i,
  input  logic [ROW_W-1:0] cfg_rows_i,
  input  logic [COL_W-1:0] cfg_cols_i,
  input  logic [HB_W-1:0]  cfg_hblank_i,
  input  logic [VB_W-1:0]  cfg_vblank_i,
  input  logic [PCC_W-1:0] cfg_pclk_div_i,
  input  logic             cfg_col_skip_i,
  output logic             frame_valid_o,
  output logic             line_valid_o,
  output logic             pixel_valid_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  rdt_state_e       state_q, state_d;
  rdt_frame_cfg_t   cfg_q;
  logic [CNT_W-1:0] edge_len_d;

  logic             cyc_load, cyc_dec, cyc_zero;
  logic [CNT_W-1:0] cyc_val, cyc_cnt;
  logic             rowc_load, rowc_dec, rowc_zero;
  logic [ROW_W-1:0] rowc_val, rowc_cnt;
  logic             frame_start, row_next, line_start, col_next;
  logic             fv_q, lv_q, pv_q, fv_d, lv_d;

  rdt_cfg_shadow u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (state_q == ST_LOAD),
    .row_first_i(cfg_row_first_i),
    .col_first_i(cfg_col_first_i),
    .rows_i     (cfg_rows_i),
    .cols_i     (cfg_cols_i),
    .hblank_i   (cfg_hblank_i),
    .vblank_i   (cfg_vblank_i),
    .pclk_div_i (cfg_pclk_div_i),
    .col_skip_i (cfg_col_skip_i),
    .edge_len_d (edge_len_d),
    .cfg_q      (cfg_q)
  );

  rdt_step_counter #(.W(CNT_W)) u_cyc_cnt (
    .clk(clk), .rst_n(rst_n), .load(cyc_load), .load_val(cyc_val),
    .dec(cyc_dec), .cnt_o(cyc_cnt), .zero_o(cyc_zero)
  );

  rdt_step_counter #(.W(ROW_W)) u_row_cnt (
    .clk(clk), .rst_n(rst_n), .load(rowc_load), .load_val(rowc_val),
    .dec(rowc_dec), .cnt_o(rowc_cnt), .zero_o(rowc_zero)
  );

  rdt_coord_gen u_coord (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .row_next   (row_next),
    .line_start (line_start),
    .col_next   (col_next),
    .row_first  (cfg_q.row_first),
    .col_first  (cfg_q.col_first),
    .col_skip   (cfg_q.col_skip),
    .row_o      (row_o),
    .col_o      (col_o)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    cyc_load    = 1'b0;
    cyc_dec     = 1'b0;
    cyc_val     = '0;
    rowc_load   = 1'b0;
    rowc_dec    = 1'b0;
    rowc_val    = '0;
    frame_start = 1'b0;
    row_next    = 1'b0;
    line_start  = 1'b0;
    col_next    = 1'b0;
    unique case (state_q)
      ST_LOAD: begin
        state_d  = ST_SOF;
        cyc_load = 1'b1;
        cyc_val  = edge_len_d - CNT_W'(1);
      end
      ST_SOF: begin
        if (cyc_zero) begin
          state_d     = ST_LINE;
          cyc_load    = 1'b1;
          cyc_val     = CNT_W'(cfg_q.pix_count) - CNT_W'(1);
          rowc_load   = 1'b1;
          rowc_val    = cfg_q.row_count - ROW_W'(1);
          frame_start = 1'b1;
          line_start  = 1'b1;
        end else begin
          cyc_dec = 1'b1;
        end
      end
      ST_LINE: begin
        if (cyc_zero) begin
          cyc_load = 1'b1;
          if (rowc_zero) begin
            state_d = ST_EOF;
            cyc_val = cfg_q.edge_len - CNT_W'(1);
          end else begin
            state_d  = ST_HBL;
            cyc_val  = cfg_q.hbl_len - CNT_W'(1);
            rowc_dec = 1'b1;
          end
        end else begin
          cyc_dec  = 1'b1;
          col_next = 1'b1;
        end
      end
      ST_HBL: begin
        if (cyc_zero) begin
          state_d    = ST_LINE;
          cyc_load   = 1'b1;
          cyc_val    = CNT_W'(cfg_q.pix_count) - CNT_W'(1);
          row_next   = 1'b1;
          line_start = 1'b1;
        end else begin
          cyc_dec = 1'b1;
        end
      end
      ST_EOF: begin
        if (cyc_zero) begin
          if (cfg_q.vbl_rows == '0) begin
            state_d = ST_LOAD;
          end else begin
            state_d   = ST_VBL;
            cyc_load  = 1'b1;
            cyc_val   = cfg_q.row_len - CNT_W'(1);
            rowc_load = 1'b1;
            rowc_val  = ROW_W'(cfg_q.vbl_rows) - ROW_W'(1);
          end
        end else begin
          cyc_dec = 1'b1;
        end
      end
      ST_VBL: begin
        if (cyc_zero) begin
          if (rowc_zero) begin
            state_d = ST_LOAD;
          end else begin
            rowc_dec = 1'b1;
            cyc_load = 1'b1;
            cyc_val  = cfg_q.row_len - CNT_W'(1);
          end
        end else begin
          cyc_dec = 1'b1;
        end
      end
      default: state_d = ST_LOAD;
    endcase
    fv_d = (state_d == ST_SOF) || (state_d == ST_LINE) ||
           (state_d == ST_HBL) || (state_d == ST_EOF);
    lv_d = (state_d == ST_LINE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      fv_q    <= 1'b0;
      lv_q    <= 1'b0;
      pv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      fv_q    <= fv_d;
      lv_q    <= lv_d;
      pv_q    <= lv_d;
    end
  end

  assign frame_valid_o = fv_q;
  assign line_valid_o  = lv_q;
  assign pixel_valid_o = pv_q;

  AST_LV_INSIDE_FV: assert property (@(posedge clk) disable iff (!rst_n)
    lv_q |-> fv_q); // R2
  AST_FV_LEADS_LV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lv_q) |-> $past(fv_q)); // R2
  AST_FV_TRAILS_LV: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fv_q) |-> !$past(lv_q)); // R3
  AST_COL_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_q && $past(lv_q)) |->
      (col_o == $past(col_o) + (cfg_q.col_skip ? COL_W'(2) : COL_W'(1)))); // R8
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lv_q) && $past(fv_q) && (state_q == ST_LINE) && !$past(state_q == ST_SOF))
      |-> (row_o == $past(row_o) + ROW_W'(1))); // R7
endmodule

// File: tb/sensor_readout_timer_test.sv
module sensor_readout_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CYCLE_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] c_rs = '0;
  logic [9:0] c_cs = '0;
  logic [8:0] c_h = '0;
  logic [9:0] c_w = '0;
  logic [9:0] c_hb = '0;
  logic [7:0] c_vb = '0;
  logic [7:0] c_pcc = '0;
  logic       c_skip = 1'b0;
  logic       fv, lv, pv;
  logic [8:0] row;
  logic [9:0] col;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit timeout = 1'b0;
  bit done = 1'b0;

  // pending configuration applied on the first pixel of a frame
  logic [8:0] n_rs, n_h;
  logic [9:0] n_cs, n_w, n_hb;
  logic [7:0] n_vb, n_pcc;
  logic       n_skip;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_readout_timer uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_row_first_i(c_rs), .cfg_col_first_i(c_cs),
    .cfg_rows_i(c_h), .cfg_cols_i(c_w),
    .cfg_hblank_i(c_hb), .cfg_vblank_i(c_vb),
    .cfg_pclk_div_i(c_pcc), .cfg_col_skip_i(c_skip),
    .frame_valid_o(fv), .line_valid_o(lv), .pixel_valid_o(pv),
    .row_o(row), .col_o(col)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > CYCLE_LIMIT) timeout = 1'b1;
  endtask

  task automatic set_cfg(input int rs, input int cs, input int h, input int w,
                         input int hb, input int vb, input int pcc, input bit sk);
    c_rs = 9'(rs); c_cs = 10'(cs); c_h = 9'(h); c_w = 10'(w);
    c_hb = 10'(hb); c_vb = 8'(vb); c_pcc = 8'(pcc); c_skip = sk;
  endtask

  // after a change, skip to the start of a frame that uses it
  task automatic settle();
    tick();
    while (fv && !timeout) tick();
    while (!fv && !timeout) tick();
  endtask

  // called on the first clock of a frame (frame_valid just high)
  task automatic check_frame(input string tag, input bit swap_mid);
    int rf, room, rc, cf, wroom, wc, np, step, hb, nb, vexp;
    int sof, gap, vbl, rows_seen, pix, errs, bad_act, bad_exp, cnt_errs;
    bit swapped;
    rf    = (c_rs > 495) ? 495 : int'(c_rs);
    room  = 496 - rf;
    rc    = (c_h == 0) ? 1 : ((int'(c_h) > room) ? room : int'(c_h));
    cf    = (c_cs > 667) ? 667 : int'(c_cs);
    wroom = 668 - cf;
    wc    = (c_w == 0) ? 1 : ((int'(c_w) > wroom) ? wroom : int'(c_w));
    np    = c_skip ? (wc + 1) / 2 : wc;
    step  = c_skip ? 2 : 1;
    hb    = (c_hb == 0) ? 1 : int'(c_hb);
    nb    = 6 * (int'(c_pcc) + 2);
    vexp  = 1 + int'(c_vb) * (np + hb);
    errs = 0; cnt_errs = 0; bad_act = 0; bad_exp = 0;
    swapped = 1'b0; rows_seen = 0;

    sof = 0;
    while (fv && !lv && !timeout) begin sof++; tick(); end
    check(sof == nb, "R2", "start-of-frame blanking", sof, nb);

    gap = 0;
    while (fv && !timeout) begin
      pix = 0;
      while (lv && !timeout) begin
        if (swap_mid && !swapped) begin
          swapped = 1'b1;
          c_rs = n_rs; c_cs = n_cs; c_h = n_h; c_w = n_w;
          c_hb = n_hb; c_vb = n_vb; c_pcc = n_pcc; c_skip = n_skip;
        end
        if (int'(row) != rf + rows_seen || int'(col) != cf + pix * step || pv !== 1'b1) begin
          if (errs == 0) begin
            bad_act = int'(row) * 1000 + int'(col);
            bad_exp = (rf + rows_seen) * 1000 + cf + pix * step;
          end
          errs++;
        end
        pix++;
        tick();
      end
      if (pix != np) cnt_errs++;
      rows_seen++;
      gap = 0;
      while (fv && !lv && !timeout) begin
        if (pv !== 1'b0) errs++;
        gap++;
        tick();
      end
      if (fv) check(gap == hb, "R5", "blanking between rows", gap, hb);
    end
    check(gap == nb, "R3", "end-of-frame blanking", gap, nb);
    check(errs == 0, tag, "pixel order (row*1000+col)", bad_act, bad_exp);
    check(cnt_errs == 0 && rows_seen == rc, "R4", "rows with the right pixel count", rows_seen - cnt_errs, rc);

    vbl = 0;
    while (!fv && !timeout) begin
      if (lv !== 1'b0) errs++;
      vbl++;
      tick();
    end
    check(vbl == vexp, "R6", "frame gap length", vbl, vexp);
  endtask

  task automatic t_reset();
    repeat (3) begin
      tick();
      check(fv == 1'b0 && lv == 1'b0 && pv == 1'b0, "R1", "qualifiers in reset",
            {29'd0, fv, lv, pv}, 0);
    end
    rst_n = 1'b1;
    while (!fv && !timeout) tick();
    check_frame("R7", 1'b0);
  endtask

  task automatic t_basic();
    set_cfg(10, 20, 3, 8, 4, 2, 0, 1'b0);
    settle();
    check_frame("R7", 1'b0);
  endtask

  task automatic t_skip();
    set_cfg(30, 41, 2, 7, 3, 1, 1, 1'b1);
    settle();
    check_frame("R8", 1'b0);
    set_cfg(12, 100, 2, 8, 2, 0, 0, 1'b1);
    settle();
    check_frame("R8", 1'b0);
  endtask

  task automatic t_pclk_zero_hblank();
    set_cfg(50, 60, 3, 4, 0, 1, 3, 1'b0);
    settle();
    check_frame("R7", 1'b0);
  endtask

  task automatic t_black();
    set_cfg(0, 0, 2, 5, 2, 0, 0, 1'b0);
    settle();
    check_frame("R11", 1'b0);
  endtask

  task automatic t_clamp();
    set_cfg(500, 660, 5, 20, 2, 1, 0, 1'b0);
    settle();
    check_frame("R9", 1'b0);
    set_cfg(490, 700, 0, 3, 1, 0, 0, 1'b1);
    settle();
    check_frame("R9", 1'b0);
    set_cfg(494, 665, 9, 0, 1, 0, 0, 1'b0);
    settle();
    check_frame("R9", 1'b0);
  endtask

  task automatic t_midframe();
    set_cfg(5, 8, 2, 6, 2, 1, 0, 1'b0);
    settle();
    n_rs = 9'd40; n_cs = 10'd200; n_h = 9'd3; n_w = 10'd5;
    n_hb = 10'd3; n_vb = 8'd0; n_pcc = 8'd1; n_skip = 1'b1;
    check_frame("R10", 1'b1);
    check_frame("R10", 1'b0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_skip();
    t_pclk_zero_hblank();
    t_black();
    t_clamp();
    t_midframe();
    check(!timeout, "R1", "run finished before watchdog", cyc, CYCLE_LIMIT);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog expired: actual %0d expected %0d", cyc, CYCLE_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule